// File: doc/BRIEF.md
# Countdown Event Timer

This block is a 32-bit down-counter with a programmable clock divider. Software reaches it through a small word-addressed register bus. The counter steps down once per divided tick. When it moves from one to zero it sets a sticky event flag, and that flag can drive a level interrupt.

In one-shot mode the counter parks at zero once it expires. In periodic mode the counter refills from a stored reload value on the tick after it reaches zero. The live count can be written on its own, so the first expiry can be set apart from the repeating period.

Reads are combinational from the addressed register. Writes take effect at the clock edge on which the write enable is high. Only address bits 3:2 select the register.

Top module: `evt_timer`

## Requirements
- R1: After reset, the load, count, control and status registers all read zero, and irq_o is low.
- R2: Word addresses select the registers: 0x0 reload value, 0x4 live count, 0x8 control, 0xC status. Control bit 0 is run, bit 1 is periodic, bit 2 is interrupt enable, and bits 15:8 are the divider N. All other control bits read zero. Status bit 0 is the event flag.
- R3: A write to 0x0 stores the reload value and also copies it into the live count. A write to 0x4 sets the live count and leaves the reload value unchanged.
- R4: While run is set, the count decrements once every N+1 clocks. The first decrement lands N+1 clocks after the control write that sets run, so a count K from 1 to 0 fires K*(N+1) clocks after that write.
- R5: While run is clear, the count holds, and the divider phase returns to zero so that a new run starts a full N+1 period.
- R6: With periodic clear, a count that has reached zero stays at zero on later ticks.
- R7: With periodic set, the tick after the count reaches zero reloads the reload value L. This gives (L+1)*(N+1) clocks between events.
- R8: The event flag sets on the tick that moves the count from 1 to 0, and it stays set until software clears it.
- R9: Writing 1 to status bit 0 clears the flag. Writing 0 there leaves the flag unchanged.
- R10: If a new event and a clearing write fall in the same cycle, the flag ends up set.
- R11: irq_o is high exactly when the event flag and the interrupt enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Byte address of the register |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data of the addressed register |
| irq_o | output | 1 | Level interrupt |

## Verification
The flag has two drivers that can act in the same clock: the counter's expiry sets it and a software write-one clears it. The bench loads a count of one with a divider of zero and enables the timer. It then issues the clearing write on the very next bus cycle, so the write lands on the same edge as the expiry. The flag and irq_o must both read back high after that edge, and a later clearing write on its own must drop them. The full-period sweeps then show that the counter's tick spacing is unaffected.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int unsigned DIV_W     = 8;
  localparam int unsigned DIV_LSB   = 8;
  localparam logic [1:0]  IDX_LOAD  = 2'd0;
  localparam logic [1:0]  IDX_COUNT = 2'd1;
  localparam logic [1:0]  IDX_CTRL  = 2'd2;
  localparam logic [1:0]  IDX_STAT  = 2'd3;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             irq_en;
    logic             periodic;
    logic             run;
  } ctrl_t;
endpackage

// File: rtl/evt_timer_prescale.sv
module evt_timer_prescale #(
  parameter int unsigned PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [PW-1:0] div_i,
  output logic          tick_o
);
  logic [PW-1:0] phase_q;

  // >= keeps ticking if the divider is lowered below the current phase
  assign tick_o = en_i && (phase_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               phase_q <= '0;
    else if (!en_i || tick_o)  phase_q <= '0;
    else                       phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core #(
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          periodic_i,
  input  logic          ld_we_i,
  input  logic          cnt_we_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] load_o,
  output logic [CW-1:0] count_o,
  output logic          expire_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] load_q, count_q;
  logic          sw_wr;

  assign sw_wr    = ld_we_i || cnt_we_i;
  assign expire_o = tick_i && !sw_wr && (count_q == ONE);
  assign load_o   = load_q;
  assign count_o  = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q  <= '0;
      count_q <= '0;
    end else begin
      if (ld_we_i) load_q <= wdata_i;
      if (sw_wr) begin
        count_q <= wdata_i;
      end else if (tick_i) begin
        if (count_q != '0)   count_q <= count_q - ONE;
        else if (periodic_i) count_q <= load_q;
      end
    end
  end
endmodule

// File: rtl/evt_timer_status.sv
module evt_timer_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              irq_o
);
  localparam int unsigned DIV_MSB = DIV_LSB + DIV_W - 1;

  ctrl_t         ctrl_q;
  logic [1:0]    idx;
  logic          ld_we, cnt_we, ctrl_we, stat_we;
  logic          tick, expire, flag;
  logic [DW-1:0] load_w, count_w;
  logic          run_w, periodic_w, irq_en_w;

  assign idx     = addr_i[3:2];
  assign ld_we   = wr_en_i && (idx == IDX_LOAD);
  assign cnt_we  = wr_en_i && (idx == IDX_COUNT);
  assign ctrl_we = wr_en_i && (idx == IDX_CTRL);
  assign stat_we = wr_en_i && (idx == IDX_STAT);

  assign run_w      = ctrl_q.run;
  assign periodic_w = ctrl_q.periodic;
  assign irq_en_w   = ctrl_q.irq_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q.div      <= wr_data_i[DIV_MSB:DIV_LSB];
      ctrl_q.irq_en   <= wr_data_i[2];
      ctrl_q.periodic <= wr_data_i[1];
      ctrl_q.run      <= wr_data_i[0];
    end
  end

  evt_timer_prescale #(.PW(DIV_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run_w),
    .div_i  (ctrl_q.div),
    .tick_o (tick)
  );

  evt_timer_core #(.CW(DW)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .periodic_i (periodic_w),
    .ld_we_i    (ld_we),
    .cnt_we_i   (cnt_we),
    .wdata_i    (wr_data_i),
    .load_o     (load_w),
    .count_o    (count_w),
    .expire_o   (expire)
  );

  evt_timer_status u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (expire),
    .clr_i    (stat_we && wr_data_i[0]),
    .irq_en_i (irq_en_w),
    .flag_o   (flag),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (idx)
      IDX_LOAD:  rd_data_o = load_w;
      IDX_COUNT: rd_data_o = count_w;
      IDX_CTRL: begin
        rd_data_o[DIV_MSB:DIV_LSB] = ctrl_q.div;
        rd_data_o[2]               = ctrl_q.irq_en;
        rd_data_o[1]               = ctrl_q.periodic;
        rd_data_o[0]               = ctrl_q.run;
      end
      default:   rd_data_o[0] = flag;
    endcase
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [DW-1:0]     wr_data_i,
  input logic              irq_o,
  input logic              run,
  input logic              periodic,
  input logic              irq_en,
  input logic              tick,
  input logic              flag,
  input logic [DW-1:0]     load,
  input logic [DW-1:0]     count
);
  logic sw_cnt, clr_wr, hits_one;
  assign sw_cnt   = wr_en_i && (addr_i[3:2] == 2'd0 || addr_i[3:2] == 2'd1);
  assign clr_wr   = wr_en_i && (addr_i[3:2] == 2'd3) && wr_data_i[0];
  assign hits_one = tick && !sw_cnt && (count == DW'(1));

  a_r11_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en && flag));

  a_r5_hold_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !sw_cnt) |=> $stable(count));

  a_r6_park_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !periodic && count == '0 && !sw_cnt) |=> (count == '0));

  a_r4_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && count != '0 && !sw_cnt) |=> (count == $past(count) - DW'(1)));

  a_r7_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && periodic && count == '0 && !sw_cnt) |=> (count == $past(load)));

  a_r8_event_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hits_one |=> flag);

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && !hits_one) |=> !flag);

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && !clr_wr) |=> flag);
endmodule

bind evt_timer evt_timer_chk #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .irq_o     (irq_o),
  .run       (run_w),
  .periodic  (periodic_w),
  .irq_en    (irq_en_w),
  .tick      (tick),
  .flag      (flag),
  .load      (load_w),
  .count     (count_w)
);

// File: tb/evt_timer_tb_top.sv
module evt_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  evt_timer dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .addr_i    (addr),
    .wr_en_i   (wr_en),
    .wr_data_i (wdata),
    .rd_data_o (rdata),
    .irq_o     (irq)
  );

  localparam logic [3:0] A_LOAD = 4'h0, A_CNT = 4'h4, A_CTRL = 4'h8, A_STAT = 4'hC;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // all tasks start and finish just after a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic logic [31:0] ctl(input int div, input bit ien, input bit per, input bit run);
    return (32'(div) << 8) | {29'd0, ien, per, run};
  endfunction

  task automatic restart();
    wr(A_CTRL, 32'd0);
    wr(A_STAT, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_LOAD, v); chk("R1 load", v, 0);
    rd(A_CNT, v);  chk("R1 count", v, 0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_STAT, v); chk("R1 status", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R2 control field layout
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R2 ctrl readback", v, 32'h0000_FF07);
    restart();

    // R3 load copies, count write independent
    wr(A_LOAD, 32'd7);
    rd(A_CNT, v); chk("R3 load copies to count", v, 7);
    wr(A_CNT, 32'd3);
    rd(A_LOAD, v); chk("R3 load kept", v, 7);
    rd(A_CNT, v);  chk("R3 count set", v, 3);

    // R4 sweep divider and start count
    for (int d = 0; d < 4; d++) begin
      for (int k = 1; k < 5; k++) begin
        restart();
        wr(A_CNT, 32'(k));
        wr(A_CTRL, ctl(d, 1, 0, 1));
        wait_irq(n);
        chk($sformatf("R4 expiry N=%0d K=%0d", d, k), 32'(n), 32'(k * (d + 1)));
      end
    end

    // R6 one-shot parks, R8 flag sticky
    repeat (10) @(negedge clk);
    rd(A_CNT, v);  chk("R6 parked at zero", v, 0);
    rd(A_STAT, v); chk("R8 flag sticky", v, 1);
    // R9 write zero ignored, write one clears
    wr(A_STAT, 32'd0);
    rd(A_STAT, v); chk("R9 write 0 no effect", v, 1);
    wr(A_STAT, 32'd1);
    rd(A_STAT, v); chk("R9 write 1 clears", v, 0);
    chk("R9 irq low after clear", {31'd0, irq}, 0);

    // R7 periodic sweep
    for (int d = 0; d < 3; d++) begin
      for (int l = 2; l < 4; l++) begin
        restart();
        wr(A_LOAD, 32'(l));
        wr(A_CTRL, ctl(d, 1, 1, 1));
        wait_irq(n);
        chk($sformatf("R7 first N=%0d L=%0d", d, l), 32'(n), 32'(l * (d + 1)));
        for (int r = 0; r < 2; r++) begin
          wr(A_STAT, 32'd1);
          wait_irq(n);
          chk($sformatf("R7 period N=%0d L=%0d", d, l), 32'(n + 1), 32'((l + 1) * (d + 1)));
        end
      end
    end

    // R5 hold while stopped, divider phase reset
    restart();
    wr(A_CNT, 32'd100);
    wr(A_CTRL, ctl(3, 0, 0, 1));
    repeat (2) @(negedge clk);
    wr(A_CTRL, 32'd0);
    wr(A_CNT, 32'd5);
    repeat (10) @(negedge clk);
    rd(A_CNT, v); chk("R5 count holds", v, 5);
    wr(A_CNT, 32'd1);
    wr(A_CTRL, ctl(3, 1, 0, 1));
    wait_irq(n);
    chk("R5 divider phase restart", 32'(n), 4);

    // R10 set and clear in the same cycle
    restart();
    wr(A_CNT, 32'd1);
    wr(A_CTRL, ctl(0, 1, 0, 1));
    wr(A_STAT, 32'd1);
    rd(A_STAT, v); chk("R10 set beats clear", v, 1);
    chk("R10 irq high", {31'd0, irq}, 1);
    wr(A_STAT, 32'd1);
    rd(A_STAT, v); chk("R10 later clear", v, 0);

    // R11 gating
    restart();
    wr(A_CNT, 32'd2);
    wr(A_CTRL, ctl(0, 0, 0, 1));
    repeat (5) @(negedge clk);
    chk("R11 irq masked", {31'd0, irq}, 0);
    rd(A_STAT, v); chk("R11 flag set while masked", v, 1);
    wr(A_CTRL, ctl(0, 1, 0, 1));
    chk("R11 irq on enable", {31'd0, irq}, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule